// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block sits between a small 8-bit processor core and its external memory pins. It serves code fetches, data reads and data writes over a 16-bit address space. Code and data are two separate 64 KB spaces, told apart only by which strobe qualifies the access. Two 8-bit pin groups carry each external access. The low group first presents address bits 7..0 and then, in the same access, carries the data byte. The high group presents address bits 15..8 for the whole access. An address latch strobe marks the window in which the low group holds address, so a board latch can separate address from data. Code reads are qualified by an active-low code output enable. Data reads and writes use their own active-low read and write strobes.

Every external access is sequenced inside one machine cycle of `CYC_LEN` oscillator clocks (12 by default). The states, in order, are:

- `S_IDLE`: no access is running. A request is accepted here.
- `S_ADDR`: the latch strobe is high and the low group drives address. This lasts `ALE_LEN` clocks.
- `S_SETUP`: the low group is released for a read, or driven with write data for a write.
- `S_STROBE`: the selected strobe is low.
- `S_HOLD`: the strobe is high again and write data is still held.
- `S_DONE`: one clock in which the done pulse is given.

The transitions are:

- `S_IDLE` to `S_ADDR`, or to `S_ROM` for an internal code fetch.
- `S_ADDR` to `S_SETUP` at phase `ALE_LEN-1`.
- `S_SETUP` to `S_STROBE` at phase `STB_FALL-1`.
- `S_STROBE` to `S_HOLD` at phase `STB_RISE-1`.
- `S_HOLD` to `S_DONE` at phase `CYC_LEN-1`.
- `S_ROM` to `S_DONE`.
- `S_DONE` to `S_IDLE`.

A code-source select input decides whether code may come from the on-chip ROM. When it is high, code fetches below `ROM_BYTES` are served by a one-clock internal ROM lookup, in state `S_ROM`. When it is low, every code fetch goes to the external bus.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is asserted and afterwards while idle:
  - `addr_stb`, `adlo_oe`, `bus_claim`, `rom_en` and `rsp_done` are 0.
  - `code_oe_n`, `data_rd_n` and `data_wr_n` are 1.
  - `rsp_rdata` is 0.
- R2: An accepted external access occupies phases 0..11, which are the 12 clocks after the accepting edge. In phases 0..3 `addr_stb` is 1, `adlo_oe` is 1 and `adlo_out` equals address bits 7..0. In phases 4..11 `addr_stb` is 0.
- R3: During phases 0..11 of an external access, `bus_claim` is 1 and `ahi_out` equals address bits 15..8.
- R4: The request kind is encoded as 0 = code read, 1 = data read, 2 = data write. Exactly one strobe is low, in phases 5..9 only:
  - kind 0 drives `code_oe_n` low;
  - kind 1 drives `data_rd_n` low;
  - kind 2 drives `data_wr_n` low.
  The other two strobes stay 1.
- R5: For external reads, `adlo_oe` is 0 in phases 4..11. The byte on `adlo_in` during phase 9, the last clock before the strobe rises, is returned on `rsp_rdata`.
- R6: For writes, `adlo_oe` is 1 and `adlo_out` equals the write byte in phases 4..11. The data therefore stays valid from before the write strobe falls until after it rises.
- R7: A code read is served internally when `code_internal` is 1 and the address is below `ROM_BYTES`. In that case `rom_en` is 1 for the single clock after acceptance, with `rom_addr` equal to the low address bits. No strobe falls, `bus_claim` stays 0, and `rsp_done` follows one clock later with the `rom_rdata` byte. Any other code read goes to the external bus.
- R8: A request is accepted only in `S_IDLE`. Any request, including kind 3, is ignored from acceptance up to and including the done clock. A kind-3 request is never accepted.
- R9: `rsp_done` is 1 for exactly one clock per accepted access. For an external access this is the clock after phase 11. `rsp_rdata` holds its value between read completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled in idle |
| req_kind | input | 2 | 0 code read, 1 data read, 2 data write, 3 ignored |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| code_internal | input | 1 | 1 allows the internal ROM for low code addresses |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read result |
| rom_en | output | 1 | Internal ROM lookup strobe |
| rom_addr | output | ROM_AW | Internal ROM address |
| rom_rdata | input | 8 | Internal ROM byte, valid while `rom_en` is high |
| addr_stb | output | 1 | Address latch strobe, active high |
| code_oe_n | output | 1 | External code output enable, active low |
| data_rd_n | output | 1 | External data read strobe, active low |
| data_wr_n | output | 1 | External data write strobe, active low |
| adlo_out | output | 8 | Low address / data byte driven out |
| adlo_oe | output | 1 | Output enable of the low group |
| adlo_in | input | 8 | Byte read back from the low group |
| ahi_out | output | 8 | High address byte |
| bus_claim | output | 1 | Both pin groups are owned by the bus, not free for general I/O |

## Verification
The bench runs the three access kinds against a memory model. That model returns a poison byte on every read clock except the last one before the strobe rises, so a read sampled one clock early or late returns the wrong value. Writes go through the bus into the model's storage and are then read back, which separates a lost or misplaced write from a misrouted read strobe. Code fetches are issued at `ROM_BYTES-1` and `ROM_BYTES`, with the source select both high and low, to show where the internal/external split falls. Requests raised during a busy access and kind-3 requests check that nothing extra starts and no extra done pulse appears.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_AW = 16;
    localparam int XB_DW = 8;
    localparam int XB_HW = XB_AW - XB_DW;

    typedef enum logic [1:0] {
        K_CODE = 2'd0,
        K_DRD  = 2'd1,
        K_DWR  = 2'd2,
        K_RSV  = 2'd3
    } xkind_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ROM    = 3'd1,
        S_ADDR   = 3'd2,
        S_SETUP  = 3'd3,
        S_STROBE = 3'd4,
        S_HOLD   = 3'd5,
        S_DONE   = 3'd6
    } xstate_t;

endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
    parameter int CYC_LEN = 12,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    output logic [PH_W-1:0] ph
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (clr) begin
            ph <= '0;
        end else if (run) begin
            ph <= ph + 1'b1;
        end
    end

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int CYC_LEN  = 12,
    parameter int ALE_LEN  = 4,
    parameter int STB_FALL = 5,
    parameter int STB_RISE = 10,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  xkind_t          req_kind,
    input  logic            use_rom,
    input  xkind_t          kind_q,
    input  logic [PH_W-1:0] ph,
    output logic            accept,
    output logic            ph_clr,
    output logic            ph_run,
    output logic            addr_stb,
    output logic            strobe_on,
    output logic            drive_addr,
    output logic            drive_wdata,
    output logic            claim,
    output logic            rom_en,
    output logic            rom_cap,
    output logic            sample,
    output logic            done
);

    localparam logic [PH_W-1:0] PH_ADDR_END  = PH_W'(ALE_LEN - 1);
    localparam logic [PH_W-1:0] PH_SETUP_END = PH_W'(STB_FALL - 1);
    localparam logic [PH_W-1:0] PH_STB_END   = PH_W'(STB_RISE - 1);
    localparam logic [PH_W-1:0] PH_LAST      = PH_W'(CYC_LEN - 1);

    xstate_t state, state_nx;
    logic    is_write;

    assign is_write = (kind_q == K_DWR);

    // next-state logic
    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (req && (req_kind != K_RSV)) begin
                    accept = 1'b1;
                    if ((req_kind == K_CODE) && use_rom) begin
                        state_nx = S_ROM;
                    end else begin
                        state_nx = S_ADDR;
                    end
                end
            end
            S_ROM:    state_nx = S_DONE;
            S_ADDR:   if (ph == PH_ADDR_END)  state_nx = S_SETUP;
            S_SETUP:  if (ph == PH_SETUP_END) state_nx = S_STROBE;
            S_STROBE: if (ph == PH_STB_END)   state_nx = S_HOLD;
            S_HOLD:   if (ph == PH_LAST)      state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs, decoded from the registered state only
    always_comb begin
        ph_clr      = 1'b0;
        ph_run      = 1'b0;
        addr_stb    = 1'b0;
        strobe_on   = 1'b0;
        drive_addr  = 1'b0;
        drive_wdata = 1'b0;
        claim       = 1'b0;
        rom_en      = 1'b0;
        rom_cap     = 1'b0;
        sample      = 1'b0;
        done        = 1'b0;
        unique case (state)
            S_IDLE: begin
                ph_clr = 1'b1;
            end
            S_ROM: begin
                ph_clr  = 1'b1;
                rom_en  = 1'b1;
                rom_cap = 1'b1;
            end
            S_ADDR: begin
                ph_run     = 1'b1;
                addr_stb   = 1'b1;
                drive_addr = 1'b1;
                claim      = 1'b1;
            end
            S_SETUP: begin
                ph_run      = 1'b1;
                drive_wdata = is_write;
                claim       = 1'b1;
            end
            S_STROBE: begin
                ph_run      = 1'b1;
                strobe_on   = 1'b1;
                drive_wdata = is_write;
                claim       = 1'b1;
                sample      = !is_write && (ph == PH_STB_END);
            end
            S_HOLD: begin
                ph_run      = 1'b1;
                drive_wdata = is_write;
                claim       = 1'b1;
            end
            S_DONE: begin
                ph_clr = 1'b1;
                done   = 1'b1;
            end
            default: begin
                ph_clr = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
    import xbus_pkg::*;
(
    input  logic   strobe_on,
    input  xkind_t kind_q,
    output logic   code_oe_n,
    output logic   data_rd_n,
    output logic   data_wr_n
);

    always_comb begin
        code_oe_n = 1'b1;
        data_rd_n = 1'b1;
        data_wr_n = 1'b1;
        if (strobe_on) begin
            unique case (kind_q)
                K_CODE:  code_oe_n = 1'b0;
                K_DRD:   data_rd_n = 1'b0;
                K_DWR:   data_wr_n = 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  xkind_t           req_kind,
    input  logic [XB_AW-1:0] req_addr,
    input  logic [XB_DW-1:0] req_wdata,
    input  logic             sample,
    input  logic             rom_cap,
    input  logic [XB_DW-1:0] adlo_in,
    input  logic [XB_DW-1:0] rom_rdata,
    input  logic             drive_addr,
    input  logic             drive_wdata,
    input  logic             claim,
    output xkind_t           kind_q,
    output logic [XB_AW-1:0] addr_q,
    output logic [XB_DW-1:0] rdata_q,
    output logic [XB_DW-1:0] adlo_out,
    output logic             adlo_oe,
    output logic [XB_HW-1:0] ahi_out
);

    logic [XB_DW-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_CODE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            kind_q  <= req_kind;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (sample) begin
            rdata_q <= adlo_in;
        end else if (rom_cap) begin
            rdata_q <= rom_rdata;
        end
    end

    always_comb begin
        adlo_out = '0;
        if (drive_addr) begin
            adlo_out = addr_q[XB_DW-1:0];
        end else if (drive_wdata) begin
            adlo_out = wdata_q;
        end
    end

    assign adlo_oe = drive_addr || drive_wdata;
    assign ahi_out = claim ? addr_q[XB_AW-1:XB_DW] : '0;

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int CYC_LEN   = 12,
    parameter int ALE_LEN   = 4,
    parameter int STB_FALL  = 5,
    parameter int STB_RISE  = 10,
    parameter int ROM_BYTES = 4096,
    localparam int ROM_AW = $clog2(ROM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        req_kind,
    input  logic [XB_AW-1:0]  req_addr,
    input  logic [XB_DW-1:0]  req_wdata,
    input  logic              code_internal,
    output logic              rsp_done,
    output logic [XB_DW-1:0]  rsp_rdata,
    output logic              rom_en,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [XB_DW-1:0]  rom_rdata,
    output logic              addr_stb,
    output logic              code_oe_n,
    output logic              data_rd_n,
    output logic              data_wr_n,
    output logic [XB_DW-1:0]  adlo_out,
    output logic              adlo_oe,
    input  logic [XB_DW-1:0]  adlo_in,
    output logic [XB_HW-1:0]  ahi_out,
    output logic              bus_claim
);

    localparam int PH_W = $clog2(CYC_LEN);

    xkind_t           kind_in, kind_q;
    logic [XB_AW-1:0] addr_q;
    logic [PH_W-1:0]  ph;
    logic             use_rom, accept, ph_clr, ph_run, strobe_on;
    logic             drive_addr, drive_wdata, rom_cap, sample;

    assign kind_in  = xkind_t'(req_kind);
    assign use_rom  = code_internal && ({16'd0, req_addr} < ROM_BYTES);
    assign rom_addr = addr_q[ROM_AW-1:0];

    xbus_phase_ctr #(.CYC_LEN(CYC_LEN)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ph_clr),
        .run   (ph_run),
        .ph    (ph)
    );

    xbus_fsm #(
        .CYC_LEN  (CYC_LEN),
        .ALE_LEN  (ALE_LEN),
        .STB_FALL (STB_FALL),
        .STB_RISE (STB_RISE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_kind    (kind_in),
        .use_rom     (use_rom),
        .kind_q      (kind_q),
        .ph          (ph),
        .accept      (accept),
        .ph_clr      (ph_clr),
        .ph_run      (ph_run),
        .addr_stb    (addr_stb),
        .strobe_on   (strobe_on),
        .drive_addr  (drive_addr),
        .drive_wdata (drive_wdata),
        .claim       (bus_claim),
        .rom_en      (rom_en),
        .rom_cap     (rom_cap),
        .sample      (sample),
        .done        (rsp_done)
    );

    xbus_strobe_dec u_strobe (
        .strobe_on (strobe_on),
        .kind_q    (kind_q),
        .code_oe_n (code_oe_n),
        .data_rd_n (data_rd_n),
        .data_wr_n (data_wr_n)
    );

    xbus_datapath u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_kind    (kind_in),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .sample      (sample),
        .rom_cap     (rom_cap),
        .adlo_in     (adlo_in),
        .rom_rdata   (rom_rdata),
        .drive_addr  (drive_addr),
        .drive_wdata (drive_wdata),
        .claim       (bus_claim),
        .kind_q      (kind_q),
        .addr_q      (addr_q),
        .rdata_q     (rsp_rdata),
        .adlo_out    (adlo_out),
        .adlo_oe     (adlo_oe),
        .ahi_out     (ahi_out)
    );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic addr_stb,
    input logic code_oe_n,
    input logic data_rd_n,
    input logic data_wr_n,
    input logic adlo_oe,
    input logic bus_claim,
    input logic rom_en,
    input logic rsp_done
);

    // R4: never more than one strobe low
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~code_oe_n, ~data_rd_n, ~data_wr_n}) <= 1);

    // R2: the latch window never overlaps a strobe and always drives the low group
    a_r2_latch_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |-> (code_oe_n && data_rd_n && data_wr_n));

    a_r2_latch_drives: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |-> (adlo_oe && bus_claim));

    // R3: any strobe low implies the pins are claimed
    a_r3_strobe_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_oe_n || !data_rd_n || !data_wr_n) |-> bus_claim);

    // R5: the low group is released while a read strobe is low
    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_oe_n || !data_rd_n) |-> !adlo_oe);

    // R6: write data driven while the write strobe is low and as it rises
    a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr_n |-> adlo_oe);

    a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_wr_n) |-> adlo_oe);

    // R7: an internal fetch leaves the external bus untouched
    a_r7_rom_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en |-> (!bus_claim && code_oe_n));

    // R9: the done pulse is one clock wide
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

bind xbus_ctrl xbus_ctrl_chk chk_i (.*);

// File: tb/xbus_ctrl_tb_top.sv
module xbus_ctrl_tb_top;

    localparam int ROM_BYTES = 4096;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic [1:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        code_internal;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic        rom_en;
    logic [11:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic        addr_stb, code_oe_n, data_rd_n, data_wr_n;
    logic [7:0]  adlo_out;
    logic        adlo_oe;
    logic [7:0]  adlo_in;
    logic [7:0]  ahi_out;
    logic        bus_claim;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    xbus_ctrl #(.ROM_BYTES(ROM_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .code_internal(code_internal),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rom_en(rom_en),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata), .addr_stb(addr_stb),
        .code_oe_n(code_oe_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n),
        .adlo_out(adlo_out), .adlo_oe(adlo_oe), .adlo_in(adlo_in),
        .ahi_out(ahi_out), .bus_claim(bus_claim)
    );

    function automatic logic [7:0] f_rom(input logic [15:0] a);
        return 8'(a * 7 + 3);
    endfunction

    function automatic logic [7:0] f_code(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    // ---------------- external memory model ----------------
    logic [15:0] lat_a = '0;
    logic [7:0]  xram [256];
    logic [7:0]  exp_ram [256];
    int          lo_cnt = 0;

    always @(posedge clk) if (addr_stb) lat_a <= {ahi_out, adlo_out};
    always @(posedge clk) lo_cnt <= (!code_oe_n || !data_rd_n) ? lo_cnt + 1 : 0;

    // data is valid only on the last strobe-low clock
    always @* begin
        if (!code_oe_n)      adlo_in = (lo_cnt >= 4) ? f_code(lat_a) : 8'hEE;
        else if (!data_rd_n) adlo_in = (lo_cnt >= 4) ? xram[lat_a[7:0]] : 8'hEE;
        else                 adlo_in = 8'h00;
    end

    always @(posedge data_wr_n) if (rst_n) xram[lat_a[7:0]] = adlo_out;

    assign rom_rdata = rom_en ? f_rom(16'(rom_addr)) : 8'h00;

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [7:0] data;
        bit         is_read;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completion
    always @(negedge clk) begin
        if (rst_n && rsp_done && !ended) begin
            if (sbq.size() == 0) begin
                chk(0, "R8 completion with no accepted request", 32'(rsp_done), 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (e.is_read) chk(rsp_rdata == e.data, e.tag, 32'(rsp_rdata), 32'(e.data));
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic ext_access(input logic [1:0] kind, input logic [15:0] addr,
                              input logic [7:0] wd, input logic cint, input bit poke);
        exp_t e;
        bit b2 = 0, b3 = 0, b4 = 0, b56 = 0;
        if (kind == 2'd0) begin
            e.data = f_code(addr); e.is_read = 1; e.tag = "R5 external code read data";
        end else if (kind == 2'd1) begin
            e.data = exp_ram[addr[7:0]]; e.is_read = 1; e.tag = "R5 data read data";
        end else begin
            exp_ram[addr[7:0]] = wd; e.data = wd; e.is_read = 0; e.tag = "R6 write";
        end
        sbq.push_back(e);
        req = 1; req_kind = kind; req_addr = addr; req_wdata = wd; code_internal = cint;
        @(negedge clk);
        req = 0; req_addr = 16'hDEAD; req_wdata = 8'h11;
        for (int ph = 0; ph < 12; ph++) begin
            bit low = (ph >= 5) && (ph <= 9);
            if (ph < 4) begin
                if (!(addr_stb && adlo_oe && adlo_out == addr[7:0])) b2 = 1;
            end else begin
                if (addr_stb) b2 = 1;
                if (kind == 2'd2) begin
                    if (!(adlo_oe && adlo_out == wd)) b56 = 1;
                end else if (adlo_oe) b56 = 1;
            end
            if (!(bus_claim && ahi_out == addr[15:8])) b3 = 1;
            if (code_oe_n != !(low && kind == 2'd0)) b4 = 1;
            if (data_rd_n != !(low && kind == 2'd1)) b4 = 1;
            if (data_wr_n != !(low && kind == 2'd2)) b4 = 1;
            if (rsp_done) b4 = 1;
            if (poke && ph == 6) begin
                req = 1; req_kind = 2'd2; req_addr = 16'h0055; req_wdata = 8'h99;
            end
            @(negedge clk);
            req = 0;
        end
        chk(!b2, "R2 latch window and low address", 32'(b2), 0);
        chk(!b3, "R3 high address and claim", 32'(b3), 0);
        chk(!b4, "R4 strobe timing and selection", 32'(b4), 0);
        chk(!b56, (kind == 2'd2) ? "R6 write data on low group" : "R5 low group released",
            32'(b56), 0);
        chk(rsp_done == 1'b1, "R9 done after phase 11", 32'(rsp_done), 1);
        @(negedge clk);
        chk(rsp_done == 1'b0 && bus_claim == 1'b0, "R9 done single clock", 32'({rsp_done, bus_claim}), 0);
    endtask

    task automatic rom_access(input logic [15:0] addr);
        exp_t e;
        e.data = f_rom(16'(addr[11:0])); e.is_read = 1; e.tag = "R7 internal ROM data";
        sbq.push_back(e);
        req = 1; req_kind = 2'd0; req_addr = addr; code_internal = 1;
        @(negedge clk);
        req = 0;
        chk(rom_en && rom_addr == addr[11:0] && !bus_claim && code_oe_n && !addr_stb,
            "R7 internal fetch stays off the bus", 32'({rom_en, rom_addr}), 32'({1'b1, addr[11:0]}));
        @(negedge clk);
        chk(rsp_done == 1'b1 && !rom_en, "R7 internal fetch done", 32'(rsp_done), 1);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R9 internal done single clock", 32'(rsp_done), 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        bit quiet;
        for (int i = 0; i < 256; i++) begin xram[i] = 8'h00; exp_ram[i] = 8'h00; end
        rst_n = 0; req = 0; req_kind = 0; req_addr = 0; req_wdata = 0; code_internal = 0;
        repeat (3) @(negedge clk);
        chk(!addr_stb && code_oe_n && data_rd_n && data_wr_n && !adlo_oe && !bus_claim
            && !rom_en && !rsp_done && rsp_rdata == 8'h00, "R1 outputs in reset",
            32'({addr_stb, code_oe_n, data_rd_n, data_wr_n, adlo_oe, bus_claim, rom_en, rsp_done}),
            32'b0111_0000);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!addr_stb && code_oe_n && data_rd_n && data_wr_n && !adlo_oe && !bus_claim
            && !rsp_done, "R1 idle after reset", 32'({addr_stb, bus_claim, rsp_done}), 0);

        // writes then reads with varied bit patterns
        ext_access(2'd2, 16'h3412, 8'h5C, 0, 0);
        ext_access(2'd2, 16'h80AB, 8'hC7, 0, 0);
        ext_access(2'd2, 16'hFF00, 8'hFF, 0, 0);
        ext_access(2'd1, 16'h3412, 8'h00, 0, 0);
        ext_access(2'd1, 16'h80AB, 8'h00, 0, 0);
        ext_access(2'd1, 16'hFF00, 8'h00, 0, 0);
        ext_access(2'd1, 16'h00FF, 8'h00, 0, 0);

        // code source selection (R7)
        ext_access(2'd0, 16'h0123, 8'h00, 0, 0);
        rom_access(16'h0123);
        rom_access(16'h0FFF);
        ext_access(2'd0, 16'h1000, 8'h00, 1, 0);
        ext_access(2'd0, 16'hA5F0, 8'h00, 1, 0);

        // requests while busy are ignored (R8)
        ext_access(2'd1, 16'h2233, 8'h00, 0, 1);
        ext_access(2'd2, 16'h1234, 8'h3A, 0, 1);
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0 && !bus_claim, "R8 no extra access after busy request",
            32'(sbq.size()), 0);
        ext_access(2'd1, 16'h0055, 8'h00, 0, 0);

        // kind 3 is never accepted (R8)
        req = 1; req_kind = 2'd3; req_addr = 16'h4455; code_internal = 0;
        @(negedge clk);
        req = 0;
        quiet = 1;
        for (int i = 0; i < 15; i++) begin
            if (bus_claim || rom_en || rsp_done || !code_oe_n || !data_rd_n || !data_wr_n) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R8 kind 3 ignored", 32'(quiet), 1);
        chk(rsp_rdata == 8'h00, "R9 read result held across ignored request", 32'(rsp_rdata), 0);

        ext_access(2'd1, 16'h3412, 8'h00, 0, 0);
        repeat (2) @(negedge clk);
        chk(sbq.size() == 0, "R9 every access completed once", 32'(sbq.size()), 0);
        finish_run();
    end

endmodule